// File: doc/BRIEF.md
# Dual-Clock Split FIFO

This block is a 64-bit buffer that sits between a write clock domain and a read clock domain. It can run as one queue of 16 words. It can also be split into two separate queues of 8 words each, called bank 0 and bank 1. A 2-bit command input does two jobs: it clears one bank, or it picks the bank that writes, reads and flags act on. The write side and the read side exchange their pointers as Gray codes through two-stage synchronizers.

All three status outputs are active low:
- `empty_no` means the selected bank has nothing to read.
- `full_no` means the selected bank has no free slot.
- `half_no` means the selected bank is at least half full.

A write is refused while the bank is full, and a read is refused while it is empty. After a bank is cleared, the first enabled write edge only arms the write side and stores nothing. This single-edge latency applies only after a clear. It does not apply when a queue drains to empty in normal use.

Top module: `dcf_fifo`

## Requirements
- R1: With `single_i`=1 the block is one queue of 16 words, and words come out in the order they were written.
- R2: With `single_i`=0 the block is two independent 8-word queues. `rs_i` encodes: 00 clears bank 0, 01 clears bank 1, 10 selects bank 0, 11 selects bank 1. Writes and reads take effect only while `rs_i[1]`=1. Flags and `rdata_o` follow the bank named by `rs_i[0]` (always bank 0 when `single_i`=1). Clearing one bank leaves the other bank's contents and flags unchanged.
- R3: A word is stored on a rising `wclk_i` edge when `wen_ni`=0 and the selected bank is not full. A write attempted while full is dropped.
- R4: The read pointer advances on a rising `rclk_i` edge when `ren_ni`=0 and the selected bank is not empty. A read attempted while empty changes nothing.
- R5: After `rst_ni` or a bank clear: `empty_no`=0, `full_no`=1, `half_no`=1.
- R6: The first enabled write edge after a reset or clear is discarded, and storage starts with the second edge. A queue that drains to empty stores its next write at once.
- R7: `half_no` is 0 when the bank holds at least 8 words (16-word mode) or at least 4 words (8-word mode). Otherwise it is 1.
- R8: `full_no` is 0 when the bank holds 16 words (16-word mode) or 8 words (8-word mode).
- R9: While `empty_no`=1, `rdata_o` shows the oldest unread word of the selected bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock |
| rclk_i | input | 1 | Read clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| single_i | input | 1 | 1: one 16-word queue, 0: two 8-word queues |
| rs_i | input | 2 | Clear/select command |
| wen_ni | input | 1 | Write enable, active low |
| wdata_i | input | 64 | Write data |
| ren_ni | input | 1 | Read enable, active low |
| rdata_o | output | 64 | Oldest unread word of selected bank |
| empty_no | output | 1 | Empty flag, active low |
| full_no | output | 1 | Full flag, active low |
| half_no | output | 1 | Half-full flag, active low |

## Verification
The 16-word queue is filled with an ascending sequence. The flags are checked at 7, 8 and 16 words. Comparing the 7-word and 8-word states shows exactly where the half threshold lies. An extra write past full, followed by a complete drain, shows whether the overflow word slipped in.

A short sequence written right after reset starts with a marker word. The marker must never come out, which separates the post-clear dummy edge from a plain drop. A write into a queue that drained on its own must come out at once, which shows the latency is tied to clears only.

In split mode, the two banks are loaded with different sequences and one bank is cleared while the other is full. This shows whether the banks share storage or pointers.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  localparam int NBANK = 2;

  typedef enum logic [1:0] {
    CMD_CLR0 = 2'b00,
    CMD_CLR1 = 2'b01,
    CMD_SEL0 = 2'b10,
    CMD_SEL1 = 2'b11
  } rs_cmd_e;
endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
  parameter int W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic [W-1:0] gray_i,
  output logic [W-1:0] bin_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else if (clr_i) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= gray_i;
      s2_q <= s1_q;
    end
  end

  always_comb begin
    bin_o[W-1] = s2_q[W-1];
    for (int i = W - 2; i >= 0; i--) bin_o[i] = bin_o[i+1] ^ s2_q[i];
  end
endmodule

// File: rtl/dcf_wr_side.sv
module dcf_wr_side #(
  parameter int DEPTH = 16,
  parameter int BANK  = 0,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          single_i,
  input  logic          en_i,
  input  logic [PW-1:0] rgray_i,
  output logic [PW-1:0] gray_o,
  output logic [AW-1:0] addr_o,
  output logic          full_o,
  output logic          push_o
);
  localparam logic [PW-1:0] FULL_S = PW'(DEPTH);
  localparam logic [PW-1:0] FULL_D = PW'(DEPTH / 2);

  logic [PW-1:0] mask, ptr_q, ptr_nxt, rptr_s, fill;
  logic          armed_q;

  dcf_sync #(.W(PW)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr_i),
    .gray_i(rgray_i),
    .bin_o (rptr_s)
  );

  assign mask    = single_i ? '1 : {1'b0, {(PW-1){1'b1}}};
  assign fill    = (ptr_q - rptr_s) & mask;
  assign full_o  = fill == (single_i ? FULL_S : FULL_D);
  assign push_o  = en_i & armed_q & ~full_o;
  assign ptr_nxt = (ptr_q + 1'b1) & mask;
  assign addr_o  = single_i ? ptr_q[AW-1:0] : {1'(BANK), ptr_q[AW-2:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q   <= '0;
      gray_o  <= '0;
      armed_q <= 1'b0;
    end else if (clr_i) begin
      ptr_q   <= '0;
      gray_o  <= '0;
      armed_q <= 1'b0;
    end else begin
      if (en_i) armed_q <= 1'b1;  // first enabled edge only arms
      if (push_o) begin
        ptr_q  <= ptr_nxt;
        gray_o <= ptr_nxt ^ (ptr_nxt >> 1);
      end
    end
  end
endmodule

// File: rtl/dcf_rd_side.sv
module dcf_rd_side #(
  parameter int DEPTH = 16,
  parameter int BANK  = 0,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          single_i,
  input  logic          en_i,
  input  logic [PW-1:0] wgray_i,
  output logic [PW-1:0] gray_o,
  output logic [AW-1:0] addr_o,
  output logic          empty_o,
  output logic          half_o
);
  localparam logic [PW-1:0] HALF_S = PW'(DEPTH / 2);
  localparam logic [PW-1:0] HALF_D = PW'(DEPTH / 4);

  logic [PW-1:0] mask, ptr_q, ptr_nxt, wptr_s, fill;
  logic          pop;

  dcf_sync #(.W(PW)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr_i),
    .gray_i(wgray_i),
    .bin_o (wptr_s)
  );

  assign mask    = single_i ? '1 : {1'b0, {(PW-1){1'b1}}};
  assign fill    = (wptr_s - ptr_q) & mask;
  assign empty_o = fill == '0;
  assign half_o  = fill >= (single_i ? HALF_S : HALF_D);
  assign pop     = en_i & ~empty_o;
  assign ptr_nxt = (ptr_q + 1'b1) & mask;
  assign addr_o  = single_i ? ptr_q[AW-1:0] : {1'(BANK), ptr_q[AW-2:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      gray_o <= '0;
    end else if (clr_i) begin
      ptr_q  <= '0;
      gray_o <= '0;
    end else if (pop) begin
      ptr_q  <= ptr_nxt;
      gray_o <= ptr_nxt ^ (ptr_nxt >> 1);
    end
  end
endmodule

// File: rtl/dcf_mem.sv
module dcf_mem #(
  parameter int DW    = 64,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/dcf_fifo.sv
module dcf_fifo
  import dcf_pkg::*;
#(
  parameter int DW    = 64,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input  logic          wclk_i,
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          single_i,
  input  logic [1:0]    rs_i,
  input  logic          wen_ni,
  input  logic [DW-1:0] wdata_i,
  input  logic          ren_ni,
  output logic [DW-1:0] rdata_o,
  output logic          empty_no,
  output logic          full_no,
  output logic          half_no
);
  logic          bank_sel, run;
  logic [PW-1:0] wgray [NBANK];
  logic [PW-1:0] rgray [NBANK];
  logic [AW-1:0] waddr [NBANK];
  logic [AW-1:0] raddr [NBANK];
  logic [NBANK-1:0] clr, wr_en, rd_en, push, full, empty, half;
  logic          we;
  logic [AW-1:0] waddr_m;

  assign bank_sel = single_i ? 1'b0 : rs_i[0];
  assign run      = rs_i[1];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    assign clr[b]   = ~run & (rs_i[0] == 1'(b));
    assign wr_en[b] = run & (bank_sel == 1'(b)) & ~wen_ni;
    assign rd_en[b] = run & (bank_sel == 1'(b)) & ~ren_ni;

    dcf_wr_side #(.DEPTH(DEPTH), .BANK(b)) u_wr (
      .clk_i   (wclk_i),
      .rst_ni  (rst_ni),
      .clr_i   (clr[b]),
      .single_i(single_i),
      .en_i    (wr_en[b]),
      .rgray_i (rgray[b]),
      .gray_o  (wgray[b]),
      .addr_o  (waddr[b]),
      .full_o  (full[b]),
      .push_o  (push[b])
    );

    dcf_rd_side #(.DEPTH(DEPTH), .BANK(b)) u_rd (
      .clk_i   (rclk_i),
      .rst_ni  (rst_ni),
      .clr_i   (clr[b]),
      .single_i(single_i),
      .en_i    (rd_en[b]),
      .wgray_i (wgray[b]),
      .gray_o  (rgray[b]),
      .addr_o  (raddr[b]),
      .empty_o (empty[b]),
      .half_o  (half[b])
    );
  end

  assign we      = |push;
  assign waddr_m = push[1] ? waddr[1] : waddr[0];

  dcf_mem #(.DW(DW), .DEPTH(DEPTH)) u_mem (
    .clk_i  (wclk_i),
    .we_i   (we),
    .waddr_i(waddr_m),
    .wdata_i(wdata_i),
    .raddr_i(raddr[bank_sel]),
    .rdata_o(rdata_o)
  );

  assign full_no  = ~full[bank_sel];
  assign empty_no = ~empty[bank_sel];
  assign half_no  = ~half[bank_sel];
endmodule

// File: rtl/dcf_fifo_chk.sv
module dcf_fifo_chk #(
  parameter int PW = 5
) (
  input logic          wclk_i,
  input logic          rclk_i,
  input logic          rst_ni,
  input logic          single_i,
  input logic [1:0]    rs_i,
  input logic          wen_ni,
  input logic          ren_ni,
  input logic          empty_no,
  input logic          half_no,
  input logic [PW-1:0] wgray0_i,
  input logic [PW-1:0] rgray0_i,
  input logic          full0_i,
  input logic          empty0_i
);
  logic sel0, clr0, wr0, rd0;
  assign sel0 = single_i | ~rs_i[0];
  assign clr0 = ~rs_i[1] & ~rs_i[0];
  assign wr0  = rs_i[1] & sel0 & ~wen_ni;
  assign rd0  = rs_i[1] & sel0 & ~ren_ni;

  assert_no_overflow_R3: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (wr0 && full0_i) |=> $stable(wgray0_i));

  assert_gray_step_R3: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    !$past(clr0) |-> ($countones(wgray0_i ^ $past(wgray0_i)) <= 1));

  assert_no_underflow_R4: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (rd0 && empty0_i) |=> $stable(rgray0_i));

  assert_clear_full_R5: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    clr0 |=> !full0_i);

  assert_clear_empty_R5: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    clr0 |=> empty0_i);

  assert_dummy_edge_R6: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    ($past(clr0) && !clr0 && wr0) |=> (wgray0_i == '0));

  assert_half_not_empty_R7: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    !half_no |-> empty_no);
endmodule

bind dcf_fifo dcf_fifo_chk #(.PW(PW)) u_chk (
  .wclk_i  (wclk_i),
  .rclk_i  (rclk_i),
  .rst_ni  (rst_ni),
  .single_i(single_i),
  .rs_i    (rs_i),
  .wen_ni  (wen_ni),
  .ren_ni  (ren_ni),
  .empty_no(empty_no),
  .half_no (half_no),
  .wgray0_i(wgray[0]),
  .rgray0_i(rgray[0]),
  .full0_i (full[0]),
  .empty0_i(empty[0])
);

// File: tb/dcf_fifo_tb_top.sv
module dcf_fifo_tb_top;
  logic        wclk_i = 1'b0;
  logic        rclk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        single_i = 1'b1;
  logic [1:0]  rs_i = 2'b10;
  logic        wen_ni = 1'b1;
  logic [63:0] wdata_i = '0;
  logic        ren_ni = 1'b1;
  logic [63:0] rdata_o;
  logic        empty_no, full_no, half_no;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 wclk_i = ~wclk_i;  // 200 MHz write clock
  always #3.5 rclk_i = ~rclk_i;

  dcf_fifo dut_i (
    .wclk_i  (wclk_i),
    .rclk_i  (rclk_i),
    .rst_ni  (rst_ni),
    .single_i(single_i),
    .rs_i    (rs_i),
    .wen_ni  (wen_ni),
    .wdata_i (wdata_i),
    .ren_ni  (ren_ni),
    .rdata_o (rdata_o),
    .empty_no(empty_no),
    .full_no (full_no),
    .half_no (half_no)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put(input logic [63:0] d);
    @(negedge wclk_i);
    wen_ni  = 1'b0;
    wdata_i = d;
    @(negedge wclk_i);
    wen_ni = 1'b1;
  endtask

  task automatic take();
    @(negedge rclk_i);
    ren_ni = 1'b0;
    @(negedge rclk_i);
    ren_ni = 1'b1;
  endtask

  task automatic settle();
    repeat (6) @(negedge rclk_i);
  endtask

  task automatic clear_bank(input logic b);
    @(negedge wclk_i);
    rs_i = {1'b0, b};
    #60;
    rs_i = {1'b1, b};
    settle();
  endtask

  task automatic t_reset();
    check("R5 empty after reset", 64'(empty_no), 64'd0);
    check("R5 full after reset", 64'(full_no), 64'd1);
    check("R5 half after reset", 64'(half_no), 64'd1);
  endtask

  task automatic t_dummy();
    put(64'hA1);
    settle();
    check("R6 dummy edge stores nothing", 64'(empty_no), 64'd0);
    put(64'hB2);
    put(64'hC3);
    settle();
    check("R6 second edge stored", 64'(empty_no), 64'd1);
    check("R9 head after dummy", rdata_o, 64'hB2);
    take();
    settle();
    check("R4 read advances", rdata_o, 64'hC3);
    take();
    settle();
    check("R4 drained empty", 64'(empty_no), 64'd0);
    take();  // read while empty
    put(64'hD4);
    settle();
    check("R6 no latency after drain", 64'(empty_no), 64'd1);
    check("R4 empty read ignored", rdata_o, 64'hD4);
    take();
    settle();
    check("R4 empty again", 64'(empty_no), 64'd0);
  endtask

  task automatic t_fill16();
    for (int i = 0; i < 7; i++) put(64'h100 + 64'(i));
    settle();
    check("R7 half high at 7", 64'(half_no), 64'd1);
    put(64'h107);
    settle();
    check("R7 half low at 8", 64'(half_no), 64'd0);
    check("R8 not full at 8", 64'(full_no), 64'd1);
    for (int i = 8; i < 16; i++) put(64'h100 + 64'(i));
    settle();
    check("R8 full at 16", 64'(full_no), 64'd0);
    put(64'hDEAD);  // overflow attempt
    settle();
    for (int i = 0; i < 16; i++) begin
      check("R1 order in 16-word queue", rdata_o, 64'h100 + 64'(i));
      take();
      settle();
      if (i == 8) check("R7 half high at 7 left", 64'(half_no), 64'd1);
      if (i == 0) check("R8 full released", 64'(full_no), 64'd1);
    end
    check("R3 overflow word dropped", 64'(empty_no), 64'd0);
  endtask

  task automatic t_dual();
    single_i = 1'b0;
    clear_bank(1'b0);
    clear_bank(1'b1);
    rs_i = 2'b10;
    settle();
    check("R5 bank0 cleared", 64'(empty_no), 64'd0);
    put(64'hFF);  // dummy
    for (int i = 0; i < 4; i++) put(64'h200 + 64'(i));
    settle();
    check("R7 bank0 half at 4", 64'(half_no), 64'd0);
    check("R8 bank0 not full at 4", 64'(full_no), 64'd1);
    for (int i = 4; i < 8; i++) put(64'h200 + 64'(i));
    settle();
    check("R8 bank0 full at 8", 64'(full_no), 64'd0);
    rs_i = 2'b11;
    settle();
    check("R2 bank1 empty", 64'(empty_no), 64'd0);
    check("R2 bank1 not full", 64'(full_no), 64'd1);
    put(64'hEE);  // dummy
    put(64'h300);
    put(64'h301);
    settle();
    check("R2 bank1 has data", 64'(empty_no), 64'd1);
    check("R7 bank1 half high at 2", 64'(half_no), 64'd1);
    check("R2 bank1 head", rdata_o, 64'h300);
    take();
    settle();
    check("R2 bank1 second", rdata_o, 64'h301);
    clear_bank(1'b1);
    check("R5 bank1 cleared", 64'(empty_no), 64'd0);
    rs_i = 2'b10;
    settle();
    check("R2 bank0 untouched full", 64'(full_no), 64'd0);
    for (int i = 0; i < 8; i++) begin
      check("R2 bank0 order", rdata_o, 64'h200 + 64'(i));
      take();
      settle();
    end
    check("R2 bank0 drained", 64'(empty_no), 64'd0);
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #23 rst_ni = 1'b1;
    settle();
    t_reset();
    t_dummy();
    t_fill16();
    t_dual();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule